// File: doc/BRIEF.md
# Framed Parallel-to-Serial Word Transmitter

This block takes a 22-bit parallel word and sends it out one bit at a time as a framed serial word. Each word is captured when the word strobe is high in a system clock cycle. The strobe stands for the rising edge of the pixel clock, brought into the system clock domain. The block shifts the word out least significant bit first. A frame always opens with a start bit at 0. The 22 data bits follow. Two trailing boundary bits close the frame, and each of them carries the complement of the last data bit. Because of this framing, every frame holds at least one level change, and a receiver can find the word edges in the bit stream.

The bit rate comes from a one-cycle bit-enable strobe that arrives with the system clock. A frame takes 25 bit slots, so the bit-enable must pulse at least 25 times in each word period. A word that arrives while a frame is being sent waits in a one-word hold register. It starts on the first bit slot after the running frame ends, with no idle slot between the two frames. A serial output-enable is high only while frame bits are on the line. When the block is disabled, or has nothing to send, the output rests at the start-bit level.

Top module: `framed_word_tx`

## Requirements
- R1: After reset, `ser_out` is 0 and `ser_oe` is 0.
- R2: The first bit slot of every frame drives `ser_out` to 0 with `ser_oe` at 1. That slot begins one clock after the first `bit_en` cycle in which a captured word is waiting.
- R3: Slots 1 to 22 of a frame carry `word_in[0]` through `word_in[21]` in that order, taken from the word that was captured.
- R4: Slots 23 and 24 both carry the complement of data bit 21, and `ser_out` does not change between them.
- R5: A slot lasts from one `bit_en` cycle to the next, and `ser_out` changes only in the clock after a cycle with `bit_en` high (or after a disable). With a strobe every 4 clocks, one frame keeps `ser_oe` high for 100 clocks.
- R6: `ser_oe` is high only during frame slots. While it is low, `ser_out` is 0.
- R7: A word captured while a frame is running starts in the slot right after that frame's slot 24, so two such frames keep `ser_oe` high without a gap.
- R8: If more than one word is captured during one frame, only the last of them is sent. The earlier ones are dropped.
- R9: A word captured in the same cycle that the hold register hands its word to the shifter is kept, and it is sent as the next frame.
- R10: While `enable` is low, the frame in progress is cut off in the next clock and the held word is discarded. `ser_oe` and `ser_out` stay 0, and `word_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable; low cuts off the frame and clears the held word |
| word_valid | input | 1 | One-cycle strobe that captures `word_in` (pixel-clock rising edge) |
| word_in | input | 22 | Parallel data word |
| bit_en | input | 1 | Serial bit-clock enable; one pulse per bit slot |
| ser_out | output | 1 | Serial data, start bit first and data least significant bit first |
| ser_oe | output | 1 | High while frame bits are being driven |

## Verification
The hold register can take a new word in the same clock that it hands its current word to the shifter at a frame boundary. In that clock the word being handed over and the word just arriving must not overwrite each other. The bench follows the slots that the output shows. When the last boundary bit of a frame is showing, it waits for the clock just before the next bit strobe and pulses the word strobe in that clock. At that moment a second word is already waiting. The scoreboard then expects three complete frames in a row, in order, and `ser_oe` must stay high for exactly 300 clocks without a break.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

   // Slots per frame: one start bit, the data bits, the trailing guard bits.
   function automatic int frame_slots(input int data_w, input int guard_w);
      return 1 + data_w + guard_w;
   endfunction

endpackage

// File: rtl/fwt_word_hold.sv
module fwt_word_hold #(
   parameter int DATA_W = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_in,
   input  logic              take,
   output logic [DATA_W-1:0] held_word,
   output logic              held_full
);

   if (DATA_W < 1) begin : g_bad_width
      $error("fwt_word_hold: DATA_W must be at least 1");
   end

   // A new capture always wins. If it lands in the same cycle as a take,
   // the shifter gets the old word and the new one stays here.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word <= '0;
         held_full <= 1'b0;
      end else if (!enable) begin
         held_full <= 1'b0;
      end else if (word_valid) begin
         held_word <= word_in;
         held_full <= 1'b1;
      end else if (take) begin
         held_full <= 1'b0;
      end
   end

   AST_TAKE_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> held_full);                                        // R7

   AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && word_valid && enable) |=> held_full);              // R9

   AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !held_full);                                    // R10

endmodule

// File: rtl/fwt_frame_pack.sv
module fwt_frame_pack #(
   parameter int DATA_W  = 22,
   parameter int GUARD_W = 2,
   parameter int FRAME_W = fwt_pkg::frame_slots(DATA_W, GUARD_W)
) (
   input  logic [DATA_W-1:0]  data,
   output logic [FRAME_W-1:0] frame
);

   localparam int DATA_LO  = 1;
   localparam int GUARD_LO = DATA_LO + DATA_W;

   if (GUARD_W < 1) begin : g_bad_guard
      $error("fwt_frame_pack: GUARD_W must be at least 1");
   end
   if (FRAME_W != fwt_pkg::frame_slots(DATA_W, GUARD_W)) begin : g_bad_frame
      $error("fwt_frame_pack: FRAME_W does not match DATA_W and GUARD_W");
   end

   logic guard_level;
   assign guard_level = ~data[DATA_W-1];

   // Slot 0 is the start bit, held at 0.
   assign frame[0] = 1'b0;

   for (genvar d = 0; d < DATA_W; d++) begin : g_data
      assign frame[DATA_LO + d] = data[d];
   end

   for (genvar g = 0; g < GUARD_W; g++) begin : g_guard
      assign frame[GUARD_LO + g] = guard_level;
   end

endmodule

// File: rtl/fwt_bit_shifter.sv
module fwt_bit_shifter #(
   parameter int FRAME_W = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               bit_en,
   input  logic [FRAME_W-1:0] frame,
   input  logic               frame_ready,
   output logic               take,
   output logic               ser_out,
   output logic               ser_oe
);

   import fwt_pkg::*;

   localparam int POS_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

   if (FRAME_W < 3) begin : g_bad_frame
      $error("fwt_bit_shifter: FRAME_W must be at least 3");
   end

   tx_state_e          state;
   logic [FRAME_W-1:0] shreg;
   logic [POS_W-1:0]   pos;
   logic               at_boundary;

   assign at_boundary = (state == TX_IDLE) || (pos == LAST_POS);
   assign take        = enable && bit_en && at_boundary && frame_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         shreg <= '0;
         pos   <= '0;
      end else if (!enable) begin
         state <= TX_IDLE;
         shreg <= '0;
         pos   <= '0;
      end else if (bit_en) begin
         if (at_boundary) begin
            pos <= '0;
            if (frame_ready) begin
               state <= TX_SEND;
               shreg <= frame;
            end else begin
               state <= TX_IDLE;
               shreg <= '0;
            end
         end else begin
            shreg <= {1'b0, shreg[FRAME_W-1:1]};
            pos   <= pos + POS_W'(1);
         end
      end
   end

   assign ser_out = shreg[0];
   assign ser_oe  = (state == TX_SEND);

   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ser_oe && !ser_out));                             // R2

   AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && enable) |=> $stable(ser_out));                  // R5

   AST_GUARD_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe && enable && bit_en && pos == LAST_POS - POS_W'(1)) |=> $stable(ser_out)); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_oe |-> !ser_out);                                      // R6

endmodule

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
   parameter int DATA_W  = 22,
   parameter int GUARD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_in,
   input  logic              bit_en,
   output logic              ser_out,
   output logic              ser_oe
);

   localparam int FRAME_W = fwt_pkg::frame_slots(DATA_W, GUARD_W);

   logic [DATA_W-1:0]  held_word;
   logic               held_full;
   logic               take;
   logic [FRAME_W-1:0] frame;

   fwt_word_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .word_valid (word_valid),
      .word_in    (word_in),
      .take       (take),
      .held_word  (held_word),
      .held_full  (held_full)
   );

   fwt_frame_pack #(
      .DATA_W  (DATA_W),
      .GUARD_W (GUARD_W),
      .FRAME_W (FRAME_W)
   ) u_pack (
      .data  (held_word),
      .frame (frame)
   );

   fwt_bit_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .bit_en      (bit_en),
      .frame       (frame),
      .frame_ready (held_full),
      .take        (take),
      .ser_out     (ser_out),
      .ser_oe      (ser_oe)
   );

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!ser_oe && !ser_out));                         // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!ser_oe && !ser_out));                          // R1

endmodule

// File: tb/framed_word_tx_tb.sv
`timescale 1ns/1ps
module framed_word_tx_tb;

   localparam int DW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          word_valid = 1'b0;
   logic [DW-1:0] word_in = '0;
   logic          bit_en;
   logic          ser_out;
   logic          ser_oe;

   int unsigned bcnt = 0;
   logic        en_q = 1'b0;
   bit          exp_bits[$];
   int          exp_idx[$];
   bit          last_bit = 1'b0;
   int          shown_idx = -1;
   int          run_len = 0;
   int          last_run = 0;
   int          checks = 0;
   int          errors = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;
   string       phase = "reset";

   always #2.5 clk = ~clk;

   // One bit slot every four clocks.
   assign bit_en = (bcnt == 0);
   always @(posedge clk) begin
      bcnt <= (bcnt == 3) ? 0 : bcnt + 1;
      en_q <= bit_en;
   end

   framed_word_tx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .word_valid (word_valid),
      .word_in    (word_in),
      .bit_en     (bit_en),
      .ser_out    (ser_out),
      .ser_oe     (ser_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (%s) actual %0h expected %0h", req, phase, act, exp);
      end
   endtask

   task automatic push_frame(input logic [DW-1:0] w);
      exp_bits.push_back(1'b0);
      exp_idx.push_back(0);
      for (int i = 0; i < DW; i++) begin
         exp_bits.push_back(w[i]);
         exp_idx.push_back(i + 1);
      end
      for (int g = 0; g < 2; g++) begin
         exp_bits.push_back(~w[DW-1]);
         exp_idx.push_back(DW + 1 + g);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic send(input logic [DW-1:0] w, input bit expect_it);
      cyc(1);
      word_in    = w;
      word_valid = 1'b1;
      if (expect_it) push_frame(w);
      cyc(1);
      word_valid = 1'b0;
   endtask

   task automatic wait_oe();
      while (!ser_oe) cyc(1);
   endtask

   task automatic drain();
      while (exp_bits.size() != 0) cyc(1);
      while (ser_oe) cyc(1);
      cyc(4);
   endtask

   // Monitor: pops the expected slot value on every strobe edge.
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (ser_oe) run_len++;
         else begin
            if (run_len != 0) last_run = run_len;
            run_len = 0;
         end
         if (en_q && ser_oe) begin
            if (exp_bits.size() == 0) begin
               chk(1'b0, "R7 unexpected slot", int'(ser_out), 0);
            end else begin
               bit b;
               int i;
               string tag;
               b = exp_bits.pop_front();
               i = exp_idx.pop_front();
               tag = (i == 0) ? "R2 start" : (i <= DW) ? "R3 data" : "R4 guard";
               chk(ser_out == b, tag, int'(ser_out), int'(b));
               last_bit  = b;
               shown_idx = i;
            end
         end else if (en_q && !ser_oe) begin
            chk(ser_out == 1'b0, "R6 idle level", int'(ser_out), 0);
         end else if (!en_q && ser_oe) begin
            chk(ser_out == last_bit, "R5 slot hold", int'(ser_out), int'(last_bit));
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (%s) actual running expected finished", phase);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      chk(ser_out == 1'b0 && ser_oe == 1'b0, "R1 in reset", {ser_oe, ser_out}, 0);
      rst_n = 1'b1;
      cyc(1);
      chk(ser_out == 1'b0 && ser_oe == 1'b0, "R1 after reset", {ser_oe, ser_out}, 0);
      enable = 1'b1;
      mon_on = 1'b1;
      cyc(8);

      phase = "single frames";
      send(22'h3FFFFF, 1'b1);
      drain();
      chk(last_run == 100, "R5 frame length", last_run, 100);
      send(22'h000000, 1'b1);
      drain();
      send(22'h155555, 1'b1);
      drain();
      send(22'h2A5A3C, 1'b1);
      drain();
      chk(ser_oe == 1'b0 && ser_out == 1'b0, "R6 rest after frames", {ser_oe, ser_out}, 0);

      phase = "back to back";
      send(22'h0F0F0F, 1'b1);
      wait_oe();
      send(22'h30C30C, 1'b1);
      drain();
      chk(last_run == 200, "R7 no gap", last_run, 200);

      phase = "overwrite";
      send(22'h123456, 1'b1);
      wait_oe();
      cyc(10);
      send(22'h3EDCBA, 1'b0);
      cyc(5);
      send(22'h2BCDEF, 1'b1);
      drain();
      chk(exp_bits.size() == 0 && last_run == 200, "R8 newest wins", last_run, 200);

      phase = "same cycle";
      shown_idx = -1;
      send(22'h111111, 1'b1);
      wait_oe();
      send(22'h222222, 1'b1);
      while (shown_idx != DW + 2) cyc(1);
      while (!bit_en) cyc(1);
      word_in    = 22'h3A3A3A;
      word_valid = 1'b1;
      push_frame(22'h3A3A3A);
      cyc(1);
      word_valid = 1'b0;
      drain();
      chk(exp_bits.size() == 0 && last_run == 300, "R9 capture at handover", last_run, 300);

      phase = "disable";
      send(22'h0A0A0A, 1'b1);
      wait_oe();
      cyc(20);
      send(22'h3C3C3C, 1'b0);
      enable = 1'b0;
      cyc(1);
      chk(ser_oe == 1'b0 && ser_out == 1'b0, "R10 cut off", {ser_oe, ser_out}, 0);
      exp_bits.delete();
      exp_idx.delete();
      send(22'h155AA5, 1'b0);
      cyc(10);
      enable = 1'b1;
      last_run = 0;
      cyc(300);
      chk(last_run == 0 && run_len == 0, "R10 held word dropped", last_run + run_len, 0);
      send(22'h2F0F01, 1'b1);
      drain();
      chk(exp_bits.size() == 0 && last_run == 100, "R10 recovery", last_run, 100);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule